// File: doc/BRIEF.md
# Lockable Low-Power Watchdog Timer

This block supervises software by counting cycles of a slow watchdog clock that runs independently of the bus clock. Once enabled, the count must be cleared by software before it reaches a timeout chosen from sixteen power-of-two levels. If the timeout is reached, the block raises a system reset request and holds it until the system reset arrives. A sticky cause flag records that the watchdog fired. This flag survives the system reset, and only a power-on reset clears it.

Software works on the block through a single control word in the bus clock domain and a separate clear strobe. Both cross into the watchdog domain through a toggle handshake, so each one reaches the counter on the third watchdog clock edge after the bus edge that issued it. The control word can be frozen by a one-way lock bit, which only a system reset releases. Two low-power mode indicators can pause the count, each according to its own run bit. Two static outputs forbid the deepest sleep mode and forbid turning off the watchdog oscillator.

The counter sequencer has four states: `ST_OFF` (disabled, count held at zero), `ST_RUN` (counting), `ST_HOLD` (paused by a low-power mode) and `ST_FIRED` (reset requested). The transitions are as follows. OFF goes to RUN when the enable takes effect. RUN goes to HOLD when a pausing mode is active, and HOLD goes back to RUN on the first edge at which no pausing mode is active. RUN goes to FIRED when the incremented count reaches the limit. RUN or HOLD goes to OFF when the enable is cleared. A clear zeroes the count and keeps RUN or HOLD. FIRED leaves only on reset.

Top module: `lp_wdt`

## Requirements
- R1: After a system or power-on reset the control word reads 0, the reset request is low and both block outputs are low. After power-on reset the cause flag is also low.
- R2: The control word layout is: bit 0 enable, bits 4:1 timeout level, bit 5 run-in-mode-2, bit 6 run-in-mode-3, bit 7 deep-sleep block, bit 8 oscillator block, bit 9 lock. An accepted write is visible on the read port after the write's bus edge.
- R3: Timeout level n gives a limit of 2^(n+3)+1 watchdog cycles. After an enabling write, the reset request rises on watchdog edge 3+limit counted from the write's bus edge, and stays low on every edge before it.
- R4: A one-cycle pulse on the clear input zeroes the count on the third watchdog edge after its bus edge. The request then rises `limit` edges later. The control word is not changed.
- R5: While the enable is clear, the count is held at zero and no request is raised. Enabling again restarts the count from zero.
- R6: When mode indicator 2 (or 3) is high and its run bit is 0, every watchdog edge at which it is high leaves the count unchanged, which delays the request by that many edges. When the run bit is 1, the indicator has no effect.
- R7: The deep-sleep block output follows bit 7 and the oscillator block output follows bit 8 of the control word.
- R8: While the lock bit is set, writes are ignored: the read port, the outputs and the timeout do not change. A system reset releases the lock, and writes are accepted after it.
- R9: Once raised, the reset request stays high until reset. Clears have no effect on it.
- R10: The cause flag is set within five bus cycles of the request rising. It stays set through a system reset, and only the power-on reset clears it.
- R11: A clear or control write issued while the previous one of the same kind is still crossing is held and forwarded when the crossing completes. Two back-to-back clears therefore zero the count again on the fifth watchdog edge after the first. Two back-to-back writes apply the second word on the third edge after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset, active low; also clears the cause flag |
| wd_clk_i | input | 1 | Slow watchdog clock, asynchronous to clk_i |
| wr_en_i | input | 1 | One-cycle control write strobe (bus clock) |
| wr_data_i | input | 10 | Control word to write |
| clr_i | input | 1 | One-cycle clear strobe (bus clock) |
| lp2_i | input | 1 | Low-power mode 2 active (watchdog clock domain) |
| lp3_i | input | 1 | Low-power mode 3 active (watchdog clock domain) |
| rd_data_o | output | 10 | Current control word |
| rst_req_o | output | 1 | System reset request (watchdog clock domain) |
| wdt_cause_o | output | 1 | Sticky flag: last reset was caused by the watchdog |
| deep_sleep_block_o | output | 1 | Forbids entry to the deepest sleep mode |
| osc_block_o | output | 1 | Forbids disabling the watchdog oscillator |

## Verification
The assertions rely on the mode indicators changing only just after a watchdog clock edge, and on the write and clear strobes lasting one bus cycle. They also rely on the control word staying still while it is sampled on the watchdog side, that is, on no third write being issued while a held write is still waiting to cross. The bench drives the indicators 1 ns after a watchdog edge. It spaces its watchdog edges so that none of them coincides with a bus edge. Its only back-to-back accesses are pairs of two, which is the merging case the sequencer is designed to absorb.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Width of the timeout level field; 2**TSEL_W levels exist.
    localparam int TSEL_W = 4;
    // Control word: lock, osc block, sleep block, run3, run2, level, enable.
    localparam int CTRL_W = TSEL_W + 6;

    typedef struct packed {
        logic              lock;
        logic              osc_keep;
        logic              deep_block;
        logic              run_lp3;
        logic              run_lp2;
        logic [TSEL_W-1:0] tsel;
        logic              en;
    } wdt_ctrl_t;

    // Subset of the control word used by the counting domain.
    typedef struct packed {
        logic              run_lp3;
        logic              run_lp2;
        logic [TSEL_W-1:0] tsel;
        logic              en;
    } wdt_run_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FIRED = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/wdt_xdom_pulse.sv
// Carries a single-cycle request from the source clock to a single-cycle
// pulse in the destination clock through a toggle, a two-flop synchronizer
// and an edge detect. Requests arriving while one is in flight are merged
// into a single pending request forwarded once the acknowledge returns.
module wdt_xdom_pulse #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic                   tgl_q;
    logic                   pend_q;
    logic [SYNC_STAGES-1:0] ack_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;
    logic                   busy;

    assign busy = tgl_q ^ ack_q[LAST];

    // Source side: launch toggle or park the request.
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (!busy && (req_i || pend_q)) begin
            tgl_q  <= ~tgl_q;
            pend_q <= 1'b0;
        end else if (req_i) begin
            pend_q <= 1'b1;
        end
    end

    // Acknowledge path back into the source domain.
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= {ack_q[SYNC_STAGES-2:0], sync_q[LAST]};
    end

    // Destination side: synchronizer and edge detect register.
    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tgl_q};
            seen_q <= sync_q[LAST];
        end
    end

    assign pulse_o = sync_q[LAST] ^ seen_q;

    // A parked request never vanishes without being launched.
    assert_pend_kept_R11: assert property (@(posedge src_clk) disable iff (!rst_n)
        (pend_q && busy) |=> pend_q);

endmodule

// File: rtl/wdt_ctrl.sv
// Bus-clock side: control word with one-way lock, and the sticky cause flag.
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              fired_i,
    output wdt_ctrl_t         ctrl_o,
    output logic              wr_ok_o,
    output logic              cause_o
);
    wdt_ctrl_t  ctrl_q;
    logic [1:0] fire_sync_q;
    logic       cause_q;

    assign wr_ok_o = wr_i && !ctrl_q.lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ok_o) ctrl_q <= wdt_ctrl_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_sync_q <= '0;
        else        fire_sync_q <= {fire_sync_q[0], fired_i};
    end

    // Survives the system reset; only power-on clears it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cause_q <= 1'b0;
        else if (fire_sync_q[1]) cause_q <= 1'b1;
    end

    assign ctrl_o  = ctrl_q;
    assign cause_o = cause_q;

    assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> $stable(ctrl_q));

    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q);

endmodule

// File: rtl/wdt_core.sv
// Watchdog-clock side: configuration shadow, state machine and counter.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_LOG = 3,
    parameter int CNT_W    = BASE_LOG + (1 << TSEL_W)
) (
    input  logic     wclk,
    input  logic     rst_n,
    input  wdt_run_t cfg_bus_i,
    input  logic     cfg_load_i,
    input  logic     clr_i,
    input  logic     lp2_i,
    input  logic     lp3_i,
    output logic     req_o
);
    wdt_run_t   cfg_q;
    wdt_run_t   cfg_cur;
    wdt_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
    logic       hold;

    // The loading edge already uses the incoming word (third-edge latency).
    assign cfg_cur = cfg_load_i ? cfg_bus_i : cfg_q;
    assign hold    = (lp2_i && !cfg_cur.run_lp2) || (lp3_i && !cfg_cur.run_lp3);
    assign limit   = (CNT_W'(1) << (cfg_cur.tsel + BASE_LOG)) + CNT_W'(1);
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n)          cfg_q <= '0;
        else if (cfg_load_i) cfg_q <= cfg_bus_i;
    end

    // State register.
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OFF: begin
                cnt_d = '0;
                if (cfg_cur.en) st_d = ST_RUN;
            end
            ST_RUN, ST_HOLD: begin
                if (!cfg_cur.en) begin
                    st_d  = ST_OFF;
                    cnt_d = '0;
                end else if (clr_i) begin
                    cnt_d = '0;
                    st_d  = hold ? ST_HOLD : ST_RUN;
                end else if (hold) begin
                    st_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_inc;
                    st_d  = (cnt_inc >= limit) ? ST_FIRED : ST_RUN;
                end
            end
            ST_FIRED: begin
                st_d = ST_FIRED;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // Output logic.
    always_comb begin
        req_o = (st_q == ST_FIRED);
    end

    assert_clear_zero_R4: assert property (@(posedge wclk) disable iff (!rst_n)
        ((st_q == ST_RUN || st_q == ST_HOLD) && cfg_cur.en && clr_i) |=> (cnt_q == '0));

    assert_pause_hold_R6: assert property (@(posedge wclk) disable iff (!rst_n)
        ((st_q == ST_RUN || st_q == ST_HOLD) && cfg_cur.en && hold && !clr_i)
        |=> $stable(cnt_q));

    assert_fired_sticky_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        req_o |=> req_o);

    always_comb begin
        if (rst_n && !cfg_q.en && st_q != ST_FIRED) begin
            assert_off_idle_R5: assert (cnt_q == '0 && !req_o);
        end
    end

endmodule

// File: rtl/lp_wdt.sv
module lp_wdt
    import wdt_pkg::*;
#(
    parameter int TO_BASE_LOG = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              por_ni,
    input  logic              wd_clk_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic              lp2_i,
    input  logic              lp3_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output logic              rst_req_o,
    output logic              wdt_cause_o,
    output logic              deep_sleep_block_o,
    output logic              osc_block_o
);
    localparam int N_XCH  = 2;   // channel 0: clear, channel 1: control load
    localparam int CNT_W  = TO_BASE_LOG + (1 << TSEL_W);

    logic             rst_all_n;
    wdt_ctrl_t        ctrl;
    wdt_run_t         run_cfg;
    logic             wr_ok;
    logic             fired;
    logic [N_XCH-1:0] xreq;
    logic [N_XCH-1:0] xpulse;

    assign rst_all_n = rst_ni & por_ni;

    wdt_ctrl u_ctrl (
        .clk     (clk_i),
        .rst_n   (rst_all_n),
        .por_n   (por_ni),
        .wr_i    (wr_en_i),
        .wdata_i (wr_data_i),
        .fired_i (fired),
        .ctrl_o  (ctrl),
        .wr_ok_o (wr_ok),
        .cause_o (wdt_cause_o)
    );

    assign xreq = {wr_ok, clr_i};

    for (genvar g = 0; g < N_XCH; g++) begin : g_xch
        wdt_xdom_pulse #(.SYNC_STAGES(2)) u_xdom (
            .src_clk (clk_i),
            .dst_clk (wd_clk_i),
            .rst_n   (rst_all_n),
            .req_i   (xreq[g]),
            .pulse_o (xpulse[g])
        );
    end

    assign run_cfg = '{run_lp3: ctrl.run_lp3, run_lp2: ctrl.run_lp2,
                       tsel: ctrl.tsel, en: ctrl.en};

    wdt_core #(.BASE_LOG(TO_BASE_LOG), .CNT_W(CNT_W)) u_core (
        .wclk       (wd_clk_i),
        .rst_n      (rst_all_n),
        .cfg_bus_i  (run_cfg),
        .cfg_load_i (xpulse[1]),
        .clr_i      (xpulse[0]),
        .lp2_i      (lp2_i),
        .lp3_i      (lp3_i),
        .req_o      (fired)
    );

    assign rst_req_o          = fired;
    assign rd_data_o          = CTRL_W'(ctrl);
    assign deep_sleep_block_o = ctrl.deep_block;
    assign osc_block_o        = ctrl.osc_keep;

endmodule

// File: tb/tb_lp_wdt.sv
module tb_lp_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int WD_PERIOD  = 70;
    localparam int WD_OFFSET  = 33;
    localparam int MAX_CYC    = 150000;

    logic       clk = 1'b0, wd_clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic       wr_en = 1'b0, clr = 1'b0, lp2 = 1'b0, lp3 = 1'b0;
    logic [9:0] wr_data = '0;
    logic [9:0] rd_data;
    logic       req, cause, deep_blk, osc_blk;

    int n_checks = 0, n_fail = 0;
    int wd_edges = 0;
    int base;

    lp_wdt dut (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wd_clk_i(wd_clk),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .clr_i(clr),
        .lp2_i(lp2), .lp3_i(lp3), .rd_data_o(rd_data), .rst_req_o(req),
        .wdt_cause_o(cause), .deep_sleep_block_o(deep_blk), .osc_block_o(osc_blk)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #(WD_OFFSET);
        forever begin
            wd_clk = 1'b1; #(WD_PERIOD/2);
            wd_clk = 1'b0; #(WD_PERIOD/2);
        end
    end
    always @(posedge wd_clk) wd_edges <= wd_edges + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic wait_to(input int target);
        while (wd_edges < target) begin
            @(posedge wd_clk); #1;
        end
    endtask

    task automatic bus_write(input int d);
        @(negedge clk); wr_en = 1'b1; wr_data = 10'(d);
        @(posedge clk); #1; wr_en = 1'b0;
        base = wd_edges;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
        base = wd_edges;
    endtask

    // Request low one edge before b+n, high at b+n.
    task automatic expire_at(input int b, input int n, input string tag);
        wait_to(b + n - 1);
        chk(req == 1'b0, tag, int'(req), 0);
        wait_to(b + n);
        chk(req == 1'b1, tag, int'(req), 1);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge wd_clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic por_reset();
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge wd_clk);
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (CLK_PERIOD * MAX_CYC) #1;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int b0;
        por_reset();
        // R1: reset state
        chk(rd_data == 0, "R1 ctrl", rd_data, 0);
        chk(req == 0 && deep_blk == 0 && osc_blk == 0, "R1 outputs",
            {req, deep_blk, osc_blk}, 0);
        chk(cause == 0, "R1 cause", cause, 0);

        // R3: sweep timeout levels 0..7
        for (int lv = 0; lv < 8; lv++) begin
            sys_reset();
            bus_write(1 | (lv << 1));
            expire_at(base, 3 + (1 << (lv + 3)) + 1, $sformatf("R3 level %0d", lv));
            if (lv == 0) begin
                pulse_clr();
                wait_to(base + 6);
                chk(req == 1, "R9 clear after fire", req, 1);
                repeat (5) @(posedge clk); #1;
                chk(cause == 1, "R10 cause set", cause, 1);
                sys_reset();
                chk(cause == 1, "R10 cause kept over system reset", cause, 1);
                chk(rd_data == 0 && req == 0, "R1 after system reset", rd_data, 0);
                por_reset();
                chk(cause == 0, "R10 cleared by power-on", cause, 0);
            end
        end

        // R2 / R7: layout and block outputs, enable off
        sys_reset();
        bus_write(10'h1E0);
        chk(rd_data == 10'h1E0, "R2 readback", rd_data, 10'h1E0);
        chk(deep_blk == 1 && osc_blk == 1, "R7 both blocks", {deep_blk, osc_blk}, 3);
        bus_write(10'h0A0);
        chk(deep_blk == 1 && osc_blk == 0, "R7 sleep only", {deep_blk, osc_blk}, 2);
        b0 = base;
        wait_to(b0 + 40);
        chk(req == 0, "R5 disabled no request", req, 0);

        // R4: clear restarts count, config untouched
        sys_reset();
        bus_write(3);
        wait_to(base + 13);
        pulse_clr();
        expire_at(base, 3 + 17, "R4 clear delays expiry");
        chk(rd_data == 3, "R4 config unchanged", rd_data, 3);

        // R5: disable mid-count, re-enable starts from zero
        sys_reset();
        bus_write(5);
        wait_to(base + 23);
        bus_write(4);
        wait_to(base + 43);
        chk(req == 0, "R5 held while disabled", req, 0);
        bus_write(5);
        expire_at(base, 3 + 33, "R5 restart from zero");

        // R6: low-power pause per mode and run bit
        for (int m = 0; m < 4; m++) begin
            int cfgw, dly;
            cfgw = 3 | ((m == 1) ? 32 : 0) | ((m == 3) ? 64 : 0);
            dly  = (m == 0 || m == 2) ? 5 : 0;
            sys_reset();
            bus_write(cfgw);
            b0 = base;
            wait_to(b0 + 3);
            if (m < 2) lp2 = 1'b1; else lp3 = 1'b1;
            wait_to(b0 + 8);
            lp2 = 1'b0; lp3 = 1'b0;
            expire_at(b0, 3 + 17 + dly, $sformatf("R6 mode case %0d", m));
        end

        // R8: lock freezes the word, system reset releases it
        sys_reset();
        bus_write(771);
        b0 = base;
        bus_write(0);
        chk(rd_data == 771, "R8 write ignored", rd_data, 771);
        chk(osc_blk == 1, "R8 output kept", osc_blk, 1);
        expire_at(b0, 3 + 17, "R8 timeout kept");
        sys_reset();
        chk(rd_data == 0, "R8 lock released", rd_data, 0);
        bus_write(4);
        chk(rd_data == 4, "R8 write after release", rd_data, 4);

        // R11: back-to-back clears merge into a later second clear
        sys_reset();
        bus_write(3);
        wait_to(base + 13);
        pulse_clr();
        b0 = base;
        pulse_clr();
        expire_at(b0, 5 + 17, "R11 merged clear");

        // R11: back-to-back writes, second word wins
        sys_reset();
        bus_write(7);
        b0 = base;
        bus_write(3);
        expire_at(b0, 3 + 17, "R11 merged write");
        chk(rd_data == 3, "R11 final word", rd_data, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule